// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and pixel position signals for a raster display. Every line is scanned as an active region, then a front porch, a sync pulse and a back porch; a frame runs through its lines in the same four regions. The active size, the porch lengths, the sync widths and the sync polarities all come from registers.

Software writes these registers through a simple write port. Each write lands in a shadow copy. While scanning, the shadow copies move into the working set only at frame end, so a partly written mode never produces a broken frame. While scanning is stopped, they move across on the next cycle. A frame-end interrupt can be masked and is cleared by writing a one. A run input starts and stops scanning.

Top module: `disp_timing_gen`

## Requirements
- R1: After synchronous reset, `de_o`, `hsync_o`, `vsync_o` and `irq_o` are low, and `x_o` and `y_o` are zero.
- R2: A line is `W` active pixels, then `HFP`, then `HSW`, then `HBP` cycles. `hsync_o` is asserted only during the `HSW` cycles. Register 0 holds `HBP` in bits [2*CW-1:CW] and `HFP` in bits [CW-1:0]. Register 1 holds `HSW`-1. Register 4 holds `H`-1 in bits [2*CW-1:CW] and `W`-1 in bits [CW-1:0].
- R3: A frame is `H` active lines, then `VFP`, then `VSW`, then `VBP` lines, with the same field layout in register 2 (porches) and register 3 (`VSW`-1). `de_o` is high only when both the pixel and the line are inside the active region.
- R4: The vertical sync width field is 4 bits wide. A written value of 15 is treated as 14, so a vertical sync lasts at most 15 lines.
- R5: Register 5 bit 0 makes `hsync_o` active-low and bit 1 makes `vsync_o` active-low. When a bit is set, the inactive level of that output is high.
- R6: While `run` is high, register writes take effect only from the first pixel of the next frame. While `run` is low, they take effect on the next cycle.
- R7: A pending flag is set on the clock edge that ends the last pixel of a frame. `irq_o` equals pending AND the enable in register 6 bit 0. Writing 1 to register 7 bit 0 clears pending. If a set and a clear fall on the same edge, the set wins.
- R8: While `run` is low, the counters rest at zero, `de_o` is low and both sync outputs sit at their inactive level from the next cycle on.
- R9: `x_o` and `y_o` give the pixel and line position of the scan. All outputs are registered, so they show the position one cycle after the counters hold it. The first cycle after `run` rises shows position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Master scan enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 2*CW | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | CW+2 | Pixel position within line |
| y_o | output | CW+2 | Line position within frame |
| irq_o | output | 1 | Masked frame-end interrupt |

## Verification
Four modes are run, each for exactly one frame:
- an asymmetric mode with non-zero porches, which tells front porch apart from back porch through where the first horizontal sync cycle falls;
- a degenerate mode with zero porches and single-cycle syncs, which exposes off-by-one errors in the minus-one fields;
- a wider mode with only the horizontal polarity inverted, which separates the two polarity bits;
- a mode that writes 15 into the vertical sync width, which shows the cap.

For each mode the data-enable, hsync and vsync cycle counts are compared with the expected values, the position sequence is followed on every cycle, and the interrupt edge is placed exactly. Directed tests cover:
- a size change made in the middle of a frame, where the current frame keeps the old size and the next frame takes the new one;
- masking and clearing of the interrupt;
- stopping the scan in the middle of a frame.

// File: rtl/disp_tg_pkg.sv
package disp_tg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_HTIME = 3'd0,
    RA_HSW   = 3'd1,
    RA_VTIME = 3'd2,
    RA_VSW   = 3'd3,
    RA_SIZE  = 3'd4,
    RA_POL   = 3'd5,
    RA_IEN   = 3'd6,
    RA_ICLR  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/disp_tg_regs.sv
module disp_tg_regs
  import disp_tg_pkg::*;
#(
  parameter int CW    = 12,
  parameter int VSW_W = 4,
  localparam int DW   = 2 * CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [CW-1:0]     a_hact_m1,
  output logic [CW-1:0]     a_hfp,
  output logic [CW-1:0]     a_hsw_m1,
  output logic [CW-1:0]     a_hbp,
  output logic [CW-1:0]     a_vact_m1,
  output logic [CW-1:0]     a_vfp,
  output logic [VSW_W-1:0]  a_vsw_m1,
  output logic [CW-1:0]     a_vbp,
  output logic              a_hneg,
  output logic              a_vneg
);
  localparam logic [VSW_W-1:0] VSW_FULL = {VSW_W{1'b1}};
  localparam logic [VSW_W-1:0] VSW_CAP  = VSW_FULL - 1'b1;

  logic [CW-1:0]    s_hact_m1, s_hfp, s_hsw_m1, s_hbp;
  logic [CW-1:0]    s_vact_m1, s_vfp, s_vbp;
  logic [VSW_W-1:0] s_vsw_m1;
  logic             s_hneg, s_vneg;

  logic [VSW_W-1:0] vsw_in;
  assign vsw_in = (wr_data[VSW_W-1:0] == VSW_FULL) ? VSW_CAP : wr_data[VSW_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s_hact_m1 <= '0; s_hfp <= '0; s_hsw_m1 <= '0; s_hbp <= '0;
      s_vact_m1 <= '0; s_vfp <= '0; s_vsw_m1 <= '0; s_vbp <= '0;
      s_hneg    <= 1'b0; s_vneg <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_HTIME: begin s_hbp <= wr_data[CW +: CW]; s_hfp <= wr_data[0 +: CW]; end
        RA_HSW:   s_hsw_m1 <= wr_data[0 +: CW];
        RA_VTIME: begin s_vbp <= wr_data[CW +: CW]; s_vfp <= wr_data[0 +: CW]; end
        RA_VSW:   s_vsw_m1 <= vsw_in;
        RA_SIZE:  begin s_vact_m1 <= wr_data[CW +: CW]; s_hact_m1 <= wr_data[0 +: CW]; end
        RA_POL:   begin s_hneg <= wr_data[0]; s_vneg <= wr_data[1]; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_hact_m1 <= '0; a_hfp <= '0; a_hsw_m1 <= '0; a_hbp <= '0;
      a_vact_m1 <= '0; a_vfp <= '0; a_vsw_m1 <= '0; a_vbp <= '0;
      a_hneg    <= 1'b0; a_vneg <= 1'b0;
    end else if (load) begin
      a_hact_m1 <= s_hact_m1; a_hfp <= s_hfp; a_hsw_m1 <= s_hsw_m1; a_hbp <= s_hbp;
      a_vact_m1 <= s_vact_m1; a_vfp <= s_vfp; a_vsw_m1 <= s_vsw_m1; a_vbp <= s_vbp;
      a_hneg    <= s_hneg;    a_vneg <= s_vneg;
    end
  end
endmodule

// File: rtl/disp_tg_axis.sv
module disp_tg_axis #(
  parameter int CW   = 12,
  parameter int SW_W = 12,
  localparam int TW  = CW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            step,
  input  logic [CW-1:0]   act_m1,
  input  logic [CW-1:0]   fp,
  input  logic [SW_W-1:0] sw_m1,
  input  logic [CW-1:0]   bp,
  output logic [TW-1:0]   cnt,
  output logic            in_act,
  output logic            in_sync,
  output logic            last
);
  logic [TW-1:0] end_act, end_fp, end_sw, end_tot;

  always_comb begin
    end_act = TW'(act_m1) + TW'(1);
    end_fp  = end_act + TW'(fp);
    end_sw  = end_fp + TW'(sw_m1) + TW'(1);
    end_tot = end_sw + TW'(bp);
  end

  assign in_act  = (cnt < end_act);
  assign in_sync = (cnt >= end_fp) && (cnt < end_sw);
  assign last    = (cnt == end_tot - TW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (step)
      cnt <= last ? '0 : cnt + TW'(1);
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_tg_pkg::*;
#(
  parameter int CW    = 12,
  parameter int VSW_W = 4,
  localparam int DW   = 2 * CW,
  localparam int TW   = CW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [TW-1:0]     x_o,
  output logic [TW-1:0]     y_o,
  output logic              irq_o
);
  logic [CW-1:0]    a_hact_m1, a_hfp, a_hsw_m1, a_hbp;
  logic [CW-1:0]    a_vact_m1, a_vfp, a_vbp;
  logic [VSW_W-1:0] a_vsw_m1;
  logic             a_hneg, a_vneg;

  logic [TW-1:0] h_cnt, v_cnt;
  logic h_act, h_sync, h_last;
  logic v_act, v_sync, v_last;
  logic fend, load;
  logic ien_q, pend_q;
  logic clr_req;

  assign fend = run && h_last && v_last;
  assign load = !run || fend;

  disp_tg_regs #(.CW(CW), .VSW_W(VSW_W)) u_regs (
    .clk(clk), .rst(rst), .load(load),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .a_hact_m1(a_hact_m1), .a_hfp(a_hfp), .a_hsw_m1(a_hsw_m1), .a_hbp(a_hbp),
    .a_vact_m1(a_vact_m1), .a_vfp(a_vfp), .a_vsw_m1(a_vsw_m1), .a_vbp(a_vbp),
    .a_hneg(a_hneg), .a_vneg(a_vneg)
  );

  disp_tg_axis #(.CW(CW), .SW_W(CW)) u_hax (
    .clk(clk), .rst(rst), .run(run), .step(1'b1),
    .act_m1(a_hact_m1), .fp(a_hfp), .sw_m1(a_hsw_m1), .bp(a_hbp),
    .cnt(h_cnt), .in_act(h_act), .in_sync(h_sync), .last(h_last)
  );

  disp_tg_axis #(.CW(CW), .SW_W(VSW_W)) u_vax (
    .clk(clk), .rst(rst), .run(run), .step(h_last),
    .act_m1(a_vact_m1), .fp(a_vfp), .sw_m1(a_vsw_m1), .bp(a_vbp),
    .cnt(v_cnt), .in_act(v_act), .in_sync(v_sync), .last(v_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o <= 1'b0; hsync_o <= 1'b0; vsync_o <= 1'b0;
      x_o  <= '0;   y_o     <= '0;
    end else begin
      de_o    <= run && h_act && v_act;
      hsync_o <= (run && h_sync) ^ a_hneg;
      vsync_o <= (run && v_sync) ^ a_vneg;
      x_o     <= run ? h_cnt : '0;
      y_o     <= run ? v_cnt : '0;
    end
  end

  assign clr_req = wr_en && (reg_addr_e'(wr_addr) == RA_ICLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en && reg_addr_e'(wr_addr) == RA_IEN)
        ien_q <= wr_data[0];
      if (fend)
        pend_q <= 1'b1;
      else if (clr_req)
        pend_q <= 1'b0;
    end
  end

  assign irq_o = pend_q && ien_q;
endmodule

// File: rtl/disp_timing_chk.sv
module disp_timing_chk #(
  parameter int CW = 12,
  localparam int TW = CW + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          clr_req,
  input logic          fend,
  input logic          pend_q,
  input logic          de_o,
  input logic [TW-1:0] x_o,
  input logic [TW-1:0] y_o,
  input logic [CW-1:0] a_hact_m1
);
  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!de_o && x_o == '0 && y_o == '0));

  // R7
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(fend));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !fend) |=> !pend_q);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !fend) |=> $stable(a_hact_m1));
endmodule

bind disp_timing_gen disp_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .clr_req(clr_req), .fend(fend),
  .pend_q(pend_q), .de_o(de_o), .x_o(x_o), .y_o(y_o), .a_hact_m1(a_hact_m1)
);

// File: tb/disp_timing_gen_test.sv
module disp_timing_gen_test;
  localparam int CW = 12;
  localparam int DW = 2 * CW;
  localparam int TW = CW + 2;

  // w, h, hfp, hsw, hbp, vfp, vsw_field, vbp, pol, frame_cycles, de_cnt, hs_cnt, vs_cnt
  localparam int NV = 4;
  localparam int VEC [0:NV-1][0:12] = '{
    '{ 8, 4, 2, 3, 1, 1,  1, 1, 0, 112, 32, 24,  28},
    '{ 5, 3, 0, 1, 0, 0,  0, 0, 3,  24, 15,  4,   6},
    '{16, 6, 4, 2, 3, 2,  2, 2, 1, 325, 96, 26,  75},
    '{ 4, 2, 1, 1, 1, 1, 15, 1, 2, 133,  8, 19, 105}
  };

  logic clk = 1'b0;
  logic rst, run, wr_en;
  logic [2:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic hsync_o, vsync_o, de_o, irq_o;
  logic [TW-1:0] x_o, y_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  disp_timing_gen #(.CW(CW)) uut (
    .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .x_o(x_o), .y_o(y_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_mode(input int v);
    wr(0, (VEC[v][4] << CW) | VEC[v][2]);
    wr(1, VEC[v][3] - 1);
    wr(2, (VEC[v][7] << CW) | VEC[v][5]);
    wr(3, VEC[v][6]);
    wr(4, ((VEC[v][1] - 1) << CW) | (VEC[v][0] - 1));
    wr(5, VEC[v][8]);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; run = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(de_o == 1'b0, "R1 de", int'(de_o), 0);
    chk(hsync_o == 1'b0 && vsync_o == 1'b0, "R1 syncs", int'({hsync_o, vsync_o}), 0);
    chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    chk(x_o == '0 && y_o == '0, "R1 position", int'(x_o) + int'(y_o), 0);

    // vector table walk: R2 R3 R4 R5 R7 R9
    for (int v = 0; v < NV; v++) begin
      automatic int ht = VEC[v][0] + VEC[v][2] + VEC[v][3] + VEC[v][4];
      automatic bit hn = VEC[v][8][0];
      automatic bit vn = VEC[v][8][1];
      automatic int n_de = 0, n_hs = 0, n_vs = 0, first_hs = 0, xy_bad = 0;
      automatic int irq_before = -1;
      run = 1'b0;
      program_mode(v);
      wr(6, 1);
      wr(7, 1);
      repeat (3) @(negedge clk);
      // R8 and R5: idle levels follow polarity
      chk(!de_o && hsync_o == hn && vsync_o == vn, "R8 idle levels",
          int'({de_o, hsync_o, vsync_o}), int'({1'b0, hn, vn}));
      run = 1'b1;
      for (int s = 1; s <= VEC[v][9]; s++) begin
        @(negedge clk);
        if (de_o) n_de++;
        if (hsync_o != hn) begin
          n_hs++;
          if (first_hs == 0) first_hs = s;
        end
        if (vsync_o != vn) n_vs++;
        if (int'(x_o) != (s - 1) % ht || int'(y_o) != (s - 1) / ht) xy_bad++;
        if (s == VEC[v][9] - 1) irq_before = int'(irq_o);
      end
      chk(n_de == VEC[v][10], "R3 de count", n_de, VEC[v][10]);
      chk(n_hs == VEC[v][11], "R2 R5 hsync count", n_hs, VEC[v][11]);
      chk(n_vs == VEC[v][12], "R3 R4 vsync count", n_vs, VEC[v][12]);
      chk(first_hs == VEC[v][0] + VEC[v][2] + 1, "R2 hsync start", first_hs,
          VEC[v][0] + VEC[v][2] + 1);
      chk(xy_bad == 0, "R9 position sequence", xy_bad, 0);
      chk(irq_before == 0, "R7 irq before frame end", irq_before, 0);
      chk(irq_o == 1'b1, "R7 irq at frame end", int'(irq_o), 1);
      run = 1'b0;
    end

    // R6 shadow: resize mid-frame, old size holds until frame end
    begin
      automatic int de1 = 0, de2 = 0;
      program_mode(0);
      repeat (3) @(negedge clk);
      run = 1'b1;
      for (int s = 1; s <= 112 + 80; s++) begin
        @(negedge clk);
        if (de_o) begin
          if (s <= 112) de1++; else de2++;
        end
        if (s == 20) begin
          wr_en = 1'b1; wr_addr = 3'd4; wr_data = DW'((3 << CW) | 3);
        end
        if (s == 21) wr_en = 1'b0;
      end
      run = 1'b0;
      chk(de1 == 32, "R6 current frame keeps size", de1, 32);
      chk(de2 == 16, "R6 next frame takes size", de2, 16);
    end

    // R7 masking and clearing
    program_mode(1);
    wr(6, 0);
    wr(7, 1);
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (24) @(negedge clk);
    run = 1'b0;
    chk(irq_o == 1'b0, "R7 masked irq", int'(irq_o), 0);
    wr(6, 1);
    chk(irq_o == 1'b1, "R7 pending seen after unmask", int'(irq_o), 1);
    wr(7, 1);
    chk(irq_o == 1'b0, "R7 cleared", int'(irq_o), 0);

    // R8 stop mid-frame
    run = 1'b1;
    repeat (10) @(negedge clk);
    chk(x_o != '0, "R8 scanning before stop", int'(x_o), 3);
    run = 1'b0;
    @(negedge clk);
    chk(!de_o && x_o == '0 && y_o == '0, "R8 stop resets position",
        int'(x_o) + int'(y_o) + int'(de_o), 0);
    chk(hsync_o == 1'b1 && vsync_o == 1'b1, "R8 R5 inactive high syncs",
        int'({hsync_o, vsync_o}), 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule